// File: doc/BRIEF.md
# Triple Programmable Interval Timer

This block is a byte-wide, memory-mapped peripheral with three independent 16-bit down-counters. Each counter runs at the device tick rate and reloads from a fixed latch value when it reaches zero. A counter whose interrupt enable is set raises its own interrupt flag on each reload. The three flags are ORed into one active-high interrupt line.

Software sees eight byte offsets. Two control registers share offset 0, and a select bit written through offset 1 picks which of them a write to offset 0 reaches. Offset 1 is also the status register on reads. Reading a counter's low-byte offset acknowledges that counter's interrupt. Nothing counts until software writes the first counter's control register with its start bit (bit 0) low. That write sets a global run gate that stays set until reset.

Top module: `tri_interval_timer`

## Requirements
- R1: While `rst` is high at a clock edge, every enable, every flag, the select bit and the run gate are cleared, and each count is loaded from its latch (32, 3200 and 801 for counters 1, 2 and 3). After reset, `irq` is 0 and the status read is 0.
- R2: A write to offset 1 stores data bit 0 as the select bit and data bit 6 as the interrupt enable of counter 2.
- R3: A write to offset 0 reaches counter 1's control register when the select bit is 1, and counter 3's control register when it is 0. Data bit 6 becomes that counter's interrupt enable.
- R4: A write to counter 1's control register with data bit 0 equal to 0 sets the run gate. Before the run gate is set, ticks leave every count unchanged. A write with bit 0 equal to 1 does not set the gate.
- R5: While the run gate is set, every clock edge with `tick` high decrements all three counts. A count that would reach zero is reloaded from its latch instead, so counter N reloads once every latch-value ticks.
- R6: A reload sets the counter's interrupt flag only if that counter's enable is 1. A disabled counter still reloads but leaves its flag unchanged.
- R7: `bus_rdata` is combinational from `bus_addr`. At offset 1 it shows the flags of counters 1, 2 and 3 in bits 0, 1 and 2, with bits 7 to 3 at 0. At every other offset it is 0x00.
- R8: A read strobe at offset 3, 5 or 7 clears the flag of counter 1, 2 or 3 respectively. A read at any other offset changes no state.
- R9: When a read-to-clear and a flag-setting reload of the same counter fall on the same edge, the flag ends at 1.
- R10: `irq` is the OR of the three interrupt flags.
- R11: Writes to offsets 2 to 7 are ignored, so the reload periods stay at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe, drives the read-to-clear side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| tick | input | 1 | Count enable for all three counters |
| irq | output | 1 | Combined interrupt, active high |

## Verification
A register write takes effect on the edge that samples `bus_wr`. A flag therefore appears on `bus_rdata` and `irq` right after the edge on which the final tick of a period is sampled, and a read-to-clear shows its result right after the edge that samples `bus_rd`. The bench drives every input on the falling clock edge and samples one falling edge later. After a run of N ticks it checks the output exactly one edge after the last tick.

The bench counts ticks from the edge that sets the run gate. It probes each period one tick short of its latch value, where no flag may be set, and again at the latch value, where the flag must be set. Because `bus_rdata` has no register, a status probe with `bus_rd` low can be sampled in the same half cycle that the address is applied.

// File: rtl/tri_interval_timer.sv
module tri_interval_timer #(
  parameter int              CW      = 16,
  parameter logic [CW-1:0]   RELOAD1 = 32,
  parameter logic [CW-1:0]   RELOAD2 = 3200,
  parameter logic [CW-1:0]   RELOAD3 = 801,
  parameter int              IE_BIT  = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tick,
  output logic       irq
);

  localparam int NT = 3;

  logic [CW-1:0] reload [NT];
  logic [CW-1:0] cnt    [NT];
  logic [NT-1:0] ien, flag, hit, ack;
  logic          sel, run;
  logic          unused_wdata;

  assign reload[0] = RELOAD1;
  assign reload[1] = RELOAD2;
  assign reload[2] = RELOAD3;
  assign unused_wdata = ^{bus_wdata[7], bus_wdata[5:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0;
      sel <= 1'b0;
      run <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == 3'd0) begin
        if (sel) begin
          ien[0] <= bus_wdata[IE_BIT];
          if (!bus_wdata[0]) run <= 1'b1;
        end else begin
          ien[2] <= bus_wdata[IE_BIT];
        end
      end else if (bus_addr == 3'd1) begin
        sel    <= bus_wdata[0];
        ien[1] <= bus_wdata[IE_BIT];
      end
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_ctr
    assign hit[i] = run && tick && (cnt[i] == CW'(1));
    assign ack[i] = bus_rd && (bus_addr == 3'(3 + 2*i));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[i]  <= reload[i];
        flag[i] <= 1'b0;
      end else begin
        if (run && tick) cnt[i] <= hit[i] ? reload[i] : cnt[i] - CW'(1);
        if (hit[i] && ien[i]) flag[i] <= 1'b1;
        else if (ack[i])      flag[i] <= 1'b0;
      end
    end

    AST_HOLD_UNTIL_RUN: assert property (@(posedge clk) disable iff (rst)
      !run |=> $stable(cnt[i])); // R4
    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (run && tick && cnt[i] == CW'(1)) |=> cnt[i] == reload[i]); // R5
    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
      $rose(flag[i]) |-> $past(ien[i] && run && tick)); // R6
    AST_CLEAR_ONLY_BY_ACK: assert property (@(posedge clk) disable iff (rst)
      $fell(flag[i]) |-> $past(bus_rd && bus_addr == 3'(3 + 2*i))); // R8
    AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
      (ack[i] && hit[i] && ien[i]) |=> flag[i]); // R9
  end

  assign bus_rdata = (bus_addr == 3'd1) ? {5'b0, flag} : 8'h00;
  assign irq       = |flag;

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[7:3] == 5'b0); // R7
  AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 3'd1) |-> (irq == (bus_rdata[2:0] != 3'b0))); // R10
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(run) |-> run); // R4

endmodule

// File: tb/sim_tri_interval_timer.sv
`timescale 1ns/1ps
module sim_tri_interval_timer;
  logic       clk = 0, rst = 1;
  logic [2:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0, tick = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       irq;
  int errors = 0, checks = 0;
  int tcount = 0;

  always #2.5 clk = ~clk;

  tri_interval_timer u0 (.clk, .rst, .bus_addr, .bus_wr, .bus_rd,
                         .bus_wdata, .bus_rdata, .tick, .irq);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_clr(logic [2:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic status(string req, logic [7:0] exp);
    bus_addr = 3'd1; #0.1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1;
    for (int k = 0; k < n; k++) @(negedge clk);
    tick = 0;
    tcount += n;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    status("R1 status after reset", 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_gate;
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h41);
    ticks(50);
    status("R4 no count before run", 8'h00);
    wr(3'd2, 8'hFF); wr(3'd3, 8'h01);
    wr(3'd0, 8'h40);
    tcount = 0;
  endtask

  task automatic t_ctr1;
    ticks(31);
    status("R5 ctr1 not yet at 31", 8'h00);
    ticks(1);
    status("R5 R11 ctr1 flag at 32", 8'h01);
    chk("R10 irq with ctr1", {7'b0, irq}, 8'h01);
    bus_addr = 3'd0; #0.1;
    chk("R7 offset0 reads 0", bus_rdata, 8'h00);
    rd_clr(3'd3);
    status("R8 ctr1 ack clears", 8'h00);
    chk("R10 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_prio;
    ticks(31);
    status("R5 ctr1 second period 63", 8'h00);
    @(negedge clk); tick = 1; bus_rd = 1; bus_addr = 3'd3;
    @(negedge clk); tick = 0; bus_rd = 0; tcount++;
    status("R9 set wins over ack", 8'h01);
    rd_clr(3'd3);
    status("R8 ack after prio", 8'h00);
  endtask

  task automatic t_ctr3;
    wr(3'd1, 8'h01); wr(3'd0, 8'h00);
    wr(3'd1, 8'h00); wr(3'd0, 8'h40);
    ticks(800 - tcount);
    status("R3 ctr3 not yet at 800", 8'h00);
    ticks(1);
    status("R3 R6 ctr3 flag at 801, ctr1 disabled", 8'h04);
    rd_clr(3'd5);
    status("R8 ctr2 ack keeps ctr3", 8'h04);
    rd_clr(3'd4);
    status("R8 offset4 read no effect", 8'h04);
    bus_addr = 3'd7; #0.1;
    chk("R7 offset7 reads 0", bus_rdata, 8'h00);
    rd_clr(3'd7);
    status("R8 ctr3 ack clears", 8'h00);
  endtask

  task automatic t_ctr2;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h40);
    ticks(3199 - tcount);
    status("R6 no flag while ctr2 counts", 8'h00);
    ticks(1);
    status("R2 ctr2 flag at 3200", 8'h02);
    chk("R10 irq with ctr2", {7'b0, irq}, 8'h01);
    rd_clr(3'd5);
    status("R8 ctr2 ack clears", 8'h00);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset;
    t_gate;
    t_ctr1;
    t_prio;
    t_ctr3;
    t_ctr2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule